// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block is the digital controller that sits in front of a 16-input multiplexed analog-to-digital converter core. It holds two programmable conversion lists of 4-bit channel numbers. The normal list has up to 16 slots. The priority list has up to 4 slots and can break into a running normal list. The controller issues one start pulse per conversion, together with the channel to sample. It takes back a done strobe with the result word and files each result: normal results go to one result register, and priority results go to one dedicated lane per slot.

Power control uses two steps. The first enable write only wakes the converter, and a programmable settling counter then runs. A later enable write, once the counter has expired, starts the normal list. Clearing the enable bit powers the converter down and drops all work in flight. Rewriting the list that is converting abandons the conversion in flight and restarts that list from its first slot.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Writing 1 to bit 0 at address 0 while powered down only starts wake-up: no conversion starts, and `pwr_on` rises exactly S+1 cycles after the write edge, where S is the settling count held at address 1.
- R2: An enable write that arrives during wake-up is ignored: the countdown is unchanged and no conversion starts. It sets the sticky `early_flag`, which a write of 0 to bit 0 at address 0 clears.
- R3: An enable write while `pwr_on` is high and the normal list is idle starts that list from slot 0. `conv_start` is then high for exactly one cycle, beginning at the clock edge after the write edge, with `conv_chan` set to that slot's channel.
- R4: The normal list converts slots 0 to L (L at address 2, bits [3:0], count minus one; slot i at address 16+i, bits [3:0]) strictly in order, and repeated channels are allowed. Each accepted done loads `reg_result` and pulses `eoc`. The last slot also pulses `reg_eos`, after which the list stays idle until the next enable write.
- R5: A pulse on `inj_trig` while powered waits for the conversion in flight to finish. It then converts priority slots 0 to J (J at address 3, bits [1:0], count minus one; slot j at address 32+j, bits [3:0]). Each result goes to lane j, `inj_results[12j+11:12j]`, and `inj_eos` pulses on the last slot. The normal list then resumes at its next slot.
- R6: Writing 0 to bit 0 at address 0 drops `pwr_on` at the write edge. No further `conv_start` follows, and a done for the dropped conversion changes no result or flag.
- R7: A write to a slot or the length of a list while one of its conversions is in flight abandons that conversion. Its done is ignored, and the list restarts from slot 0 with a fresh start pulse carrying the new contents.
- R8: A `conv_done` with no conversion outstanding changes neither `reg_result` nor any flag.
- R9: `inj_trig` while powered down, or while the priority list is already running, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the converter core |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| inj_trig | input | 1 | Request to run the priority list |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_chan | output | 4 | Channel the core samples for this conversion |
| conv_done | input | 1 | Conversion-complete strobe from the core |
| conv_data | input | 12 | Result word, valid with `conv_done` |
| reg_result | output | 12 | Last normal-list result |
| inj_results | output | 48 | Four priority-list results, lane j in bits [12j+11:12j] |
| eoc | output | 1 | Pulse for each accepted conversion |
| reg_eos | output | 1 | Pulse when the last normal slot completes |
| inj_eos | output | 1 | Pulse when the last priority slot completes |
| pwr_on | output | 1 | Converter awake and settled |
| early_flag | output | 1 | Sticky: an enable write came during wake-up |

## Verification
Some rules are checked by the assertions on every cycle: the start pulse lasts one cycle, no start occurs while powered down, every end-of-conversion or end-of-list pulse follows an accepted done, and the early flag rises only after an enable write. Other behaviour can only be shown by the bench scenarios, because it depends on what was programmed: the exact settling delay, the channel order with repeats, the resumption point after a priority break-in, the restart after a list rewrite, and the filing of results into the correct lanes.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_WAKE = 2'd1,
    PWR_ON   = 2'd2
  } pwr_state_e;

  // register addresses whose values the bench depends on
  localparam int unsigned CTRL_ADDR  = 0;
  localparam int unsigned STAB_ADDR  = 1;
  localparam int unsigned RLEN_ADDR  = 2;
  localparam int unsigned ILEN_ADDR  = 3;
  localparam int unsigned RSLOT_BASE = 16;
  localparam int unsigned ISLOT_BASE = 32;

  // a list position is final when it equals the stored count-minus-one
  function automatic logic last_slot(input int unsigned idx, input int unsigned len_m1);
    return idx == len_m1;
  endfunction

  // the settling countdown has run out
  function automatic logic wake_elapsed(input int unsigned remaining);
    return remaining == 0;
  endfunction

endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs #(
  parameter int NUM_REG    = 16,
  parameter int NUM_INJ    = 4,
  parameter int CH_W       = 4,
  parameter int ADDR_W     = 6,
  parameter int STAB_W     = 16,
  parameter int STAB_RESET = 16,
  localparam int RLEN_W    = $clog2(NUM_REG),
  localparam int ILEN_W    = $clog2(NUM_INJ)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [31:0]                       wr_data,
  output logic [NUM_REG-1:0][CH_W-1:0]      rslots,
  output logic [NUM_INJ-1:0][CH_W-1:0]      islots,
  output logic [RLEN_W-1:0]                 rlen,
  output logic [ILEN_W-1:0]                 ilen,
  output logic [STAB_W-1:0]                 stab_cycles,
  output logic                              ctrl_wr,
  output logic                              ctrl_en,
  output logic                              rlist_wr,
  output logic                              ilist_wr
);
  import adcseq_pkg::*;

  logic [NUM_REG-1:0] rslot_hit;
  logic [NUM_INJ-1:0] islot_hit;
  logic               stab_hit, rlen_hit, ilen_hit;
  logic               unused_wr_hi;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign ctrl_en  = wr_data[0];
  assign stab_hit = wr_en && (wr_addr == ADDR_W'(STAB_ADDR));
  assign rlen_hit = wr_en && (wr_addr == ADDR_W'(RLEN_ADDR));
  assign ilen_hit = wr_en && (wr_addr == ADDR_W'(ILEN_ADDR));
  assign rlist_wr = rlen_hit || (|rslot_hit);
  assign ilist_wr = ilen_hit || (|islot_hit);
  assign unused_wr_hi = ^wr_data[31:STAB_W];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_rslot
    assign rslot_hit[i] = wr_en && (wr_addr == ADDR_W'(RSLOT_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rslots[i] <= '0;
      else if (rslot_hit[i]) rslots[i] <= wr_data[CH_W-1:0];
    end
  end

  for (genvar j = 0; j < NUM_INJ; j++) begin : g_islot
    assign islot_hit[j] = wr_en && (wr_addr == ADDR_W'(ISLOT_BASE + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            islots[j] <= '0;
      else if (islot_hit[j]) islots[j] <= wr_data[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlen        <= '0;
      ilen        <= '0;
      stab_cycles <= STAB_W'(STAB_RESET);
    end else begin
      if (rlen_hit) rlen        <= wr_data[RLEN_W-1:0];
      if (ilen_hit) ilen        <= wr_data[ILEN_W-1:0];
      if (stab_hit) stab_cycles <= wr_data[STAB_W-1:0];
    end
  end

endmodule

// File: rtl/adcseq_power.sv
module adcseq_power #(
  parameter int STAB_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_en,
  input  logic [STAB_W-1:0] stab_cycles,
  output logic              pwr_on,
  output logic              start_req,
  output logic              stop_req,
  output logic              early_flag
);
  import adcseq_pkg::*;

  pwr_state_e        state;
  logic [STAB_W-1:0] wake_cnt;
  logic              wake_req, early_hit;

  assign stop_req  = ctrl_wr && !ctrl_en;
  assign wake_req  = ctrl_wr && ctrl_en && (state == PWR_OFF);
  assign early_hit = ctrl_wr && ctrl_en && (state == PWR_WAKE);
  assign start_req = ctrl_wr && ctrl_en && (state == PWR_ON);
  assign pwr_on    = (state == PWR_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PWR_OFF;
      wake_cnt   <= '0;
      early_flag <= 1'b0;
    end else if (stop_req) begin
      state      <= PWR_OFF;
      wake_cnt   <= '0;
      early_flag <= 1'b0;
    end else begin
      if (early_hit) early_flag <= 1'b1;
      case (state)
        PWR_OFF: if (wake_req) begin
          state    <= PWR_WAKE;
          wake_cnt <= stab_cycles;
        end
        PWR_WAKE: begin
          if (wake_elapsed(32'(wake_cnt))) state <= PWR_ON;
          else                             wake_cnt <= wake_cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine #(
  parameter int NUM_REG = 16,
  parameter int NUM_INJ = 4,
  parameter int CH_W    = 4,
  parameter int DATA_W  = 12,
  localparam int RLEN_W = $clog2(NUM_REG),
  localparam int ILEN_W = $clog2(NUM_INJ)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pwr_on,
  input  logic                          start_req,
  input  logic                          stop_req,
  input  logic                          inj_trig,
  input  logic                          rlist_wr,
  input  logic                          ilist_wr,
  input  logic [NUM_REG-1:0][CH_W-1:0]  rslots,
  input  logic [NUM_INJ-1:0][CH_W-1:0]  islots,
  input  logic [RLEN_W-1:0]             rlen,
  input  logic [ILEN_W-1:0]             ilen,
  input  logic                          conv_done,
  input  logic [DATA_W-1:0]             conv_data,
  output logic                          conv_start,
  output logic [CH_W-1:0]               conv_chan,
  output logic [DATA_W-1:0]             reg_result,
  output logic [NUM_INJ-1:0][DATA_W-1:0] inj_res,
  output logic                          eoc,
  output logic                          reg_eos,
  output logic                          inj_eos,
  output logic                          busy,
  output logic                          issue,
  output logic                          abandon,
  output logic                          accept_done
);
  import adcseq_pkg::*;

  logic              reg_active, inj_active, cur_inj;
  logic [RLEN_W-1:0] reg_idx;
  logic [ILEN_W-1:0] inj_idx;
  logic [CH_W-1:0]   next_chan;
  logic              inj_accept;

  // the in-flight conversion belongs to a list that is being rewritten
  assign abandon     = busy && ((rlist_wr && !cur_inj) || (ilist_wr && cur_inj));
  assign accept_done = busy && conv_done && !abandon && !stop_req;
  assign issue       = pwr_on && !stop_req && !busy && !rlist_wr && !ilist_wr &&
                       (inj_active || reg_active);
  assign next_chan   = inj_active ? islots[inj_idx] : rslots[reg_idx];
  assign inj_accept  = inj_trig && pwr_on && !inj_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_active <= 1'b0;  inj_active <= 1'b0;
      reg_idx    <= '0;    inj_idx    <= '0;
      busy       <= 1'b0;  cur_inj    <= 1'b0;
      conv_start <= 1'b0;  conv_chan  <= '0;
      reg_result <= '0;    inj_res    <= '0;
      eoc        <= 1'b0;  reg_eos    <= 1'b0;  inj_eos <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      eoc        <= 1'b0;
      reg_eos    <= 1'b0;
      inj_eos    <= 1'b0;
      if (stop_req) begin
        reg_active <= 1'b0;  inj_active <= 1'b0;
        reg_idx    <= '0;    inj_idx    <= '0;
        busy       <= 1'b0;
      end else begin
        if (start_req && !reg_active) begin
          reg_active <= 1'b1;
          reg_idx    <= '0;
        end
        if (inj_accept) begin
          inj_active <= 1'b1;
          inj_idx    <= '0;
        end
        if (rlist_wr && reg_active) reg_idx <= '0;
        if (ilist_wr && inj_active) inj_idx <= '0;
        if (abandon) busy <= 1'b0;
        if (accept_done) begin
          busy <= 1'b0;
          eoc  <= 1'b1;
          if (cur_inj) begin
            inj_res[inj_idx] <= conv_data;
            if (last_slot(32'(inj_idx), 32'(ilen))) begin
              inj_active <= 1'b0;
              inj_eos    <= 1'b1;
            end else begin
              inj_idx <= inj_idx + 1'b1;
            end
          end else begin
            reg_result <= conv_data;
            if (last_slot(32'(reg_idx), 32'(rlen))) begin
              reg_active <= 1'b0;
              reg_eos    <= 1'b1;
            end else if (!rlist_wr) begin
              reg_idx <= reg_idx + 1'b1;
            end
          end
        end
        if (issue) begin
          busy       <= 1'b1;
          cur_inj    <= inj_active;
          conv_start <= 1'b1;
          conv_chan  <= next_chan;
        end
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NUM_REG    = 16,
  parameter int NUM_INJ    = 4,
  parameter int CH_W       = 4,
  parameter int DATA_W     = 12,
  parameter int ADDR_W     = 6,
  parameter int STAB_W     = 16,
  parameter int STAB_RESET = 16,
  localparam int RLEN_W    = $clog2(NUM_REG),
  localparam int ILEN_W    = $clog2(NUM_INJ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  input  logic                      inj_trig,
  output logic                      conv_start,
  output logic [CH_W-1:0]           conv_chan,
  input  logic                      conv_done,
  input  logic [DATA_W-1:0]         conv_data,
  output logic [DATA_W-1:0]         reg_result,
  output logic [NUM_INJ*DATA_W-1:0] inj_results,
  output logic                      eoc,
  output logic                      reg_eos,
  output logic                      inj_eos,
  output logic                      pwr_on,
  output logic                      early_flag
);

  logic [NUM_REG-1:0][CH_W-1:0]   rslots;
  logic [NUM_INJ-1:0][CH_W-1:0]   islots;
  logic [RLEN_W-1:0]              rlen;
  logic [ILEN_W-1:0]              ilen;
  logic [STAB_W-1:0]              stab_cycles;
  logic                           ctrl_wr, ctrl_en, rlist_wr, ilist_wr;
  logic                           start_req, stop_req;
  logic [NUM_INJ-1:0][DATA_W-1:0] inj_res;
  // internal events brought out for the checker
  logic                           eng_busy, eng_issue, eng_abandon, eng_accept;

  adcseq_regs #(
    .NUM_REG(NUM_REG), .NUM_INJ(NUM_INJ), .CH_W(CH_W), .ADDR_W(ADDR_W),
    .STAB_W(STAB_W), .STAB_RESET(STAB_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rslots(rslots), .islots(islots), .rlen(rlen), .ilen(ilen),
    .stab_cycles(stab_cycles), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .rlist_wr(rlist_wr), .ilist_wr(ilist_wr)
  );

  adcseq_power #(.STAB_W(STAB_W)) u_power (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .stab_cycles(stab_cycles), .pwr_on(pwr_on), .start_req(start_req),
    .stop_req(stop_req), .early_flag(early_flag)
  );

  adcseq_engine #(
    .NUM_REG(NUM_REG), .NUM_INJ(NUM_INJ), .CH_W(CH_W), .DATA_W(DATA_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .start_req(start_req),
    .stop_req(stop_req), .inj_trig(inj_trig), .rlist_wr(rlist_wr),
    .ilist_wr(ilist_wr), .rslots(rslots), .islots(islots), .rlen(rlen),
    .ilen(ilen), .conv_done(conv_done), .conv_data(conv_data),
    .conv_start(conv_start), .conv_chan(conv_chan), .reg_result(reg_result),
    .inj_res(inj_res), .eoc(eoc), .reg_eos(reg_eos), .inj_eos(inj_eos),
    .busy(eng_busy), .issue(eng_issue), .abandon(eng_abandon),
    .accept_done(eng_accept)
  );

  assign inj_results = inj_res;

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              conv_start,
  input logic              conv_done,
  input logic              pwr_on,
  input logic              early_flag,
  input logic              eoc,
  input logic              reg_eos,
  input logic              inj_eos,
  input logic              eng_busy
);

  // R3: the start strobe never stretches past one cycle
  p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R6: nothing is started while the converter is not powered and settled
  p_no_start_unpowered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> !conv_start);

  // R2: the early flag only rises after an enable write
  p_early_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_flag) |-> $past(wr_en && (wr_addr == '0) && wr_data[0]));

  // R8: each end-of-conversion pulse answers a done that met an outstanding conversion
  p_eoc_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(conv_done && eng_busy));

  // R4: end of the normal list coincides with a conversion end
  p_reg_eos_with_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_eos |-> eoc);

  // R5: end of the priority list follows an accepted done and never pairs with the normal end
  p_inj_eos_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inj_eos |-> ($past(conv_done) && !reg_eos));

  // R7: a new start is issued only after the previous conversion was closed
  p_start_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(!eng_busy));

endmodule

bind adc_seq_ctrl adcseq_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .conv_start(conv_start), .conv_done(conv_done), .pwr_on(pwr_on),
  .early_flag(early_flag), .eoc(eoc), .reg_eos(reg_eos), .inj_eos(inj_eos),
  .eng_busy(eng_busy)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int DW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        inj_trig = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [11:0] reg_result;
  logic [47:0] inj_results;
  logic        eoc, reg_eos, inj_eos, pwr_on, early_flag;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inj_trig(inj_trig), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .reg_result(reg_result),
    .inj_results(inj_results), .eoc(eoc), .reg_eos(reg_eos), .inj_eos(inj_eos),
    .pwr_on(pwr_on), .early_flag(early_flag)
  );

  always #10 clk = ~clk;

  int n_checks = 0, n_err = 0;
  int st_chan [512];
  int st_data [512];
  int n_starts = 0, n_eoc = 0, n_reos = 0, n_ieos = 0;
  int exp_r [16];
  int exp_i [4];
  int rlen_m1, ilen_m1;
  int spur_req = 0, spur_seen = 0;
  bit pend = 0;
  int pend_cnt = 0, seq_no = 0;
  logic [11:0] pend_dat;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural converter: result = {channel, start sequence number}, latency 3..5
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_done = 1'b0;
      pend = 0;
    end else begin
      conv_done = 1'b0;
      if (conv_start) begin
        pend_dat = {conv_chan, 8'(seq_no)};
        if (n_starts < 512) begin
          st_chan[n_starts] = conv_chan;
          st_data[n_starts] = pend_dat;
        end
        n_starts++;
        seq_no++;
        pend = 1;
        pend_cnt = $urandom_range(5, 3);
      end else if (pend) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          conv_done = 1'b1;
          conv_data = pend_dat;
          pend = 0;
        end
      end else if (spur_req != spur_seen) begin
        spur_seen++;
        conv_done = 1'b1;
        conv_data = 12'hABC;
      end
      if (eoc) n_eoc++;
      if (reg_eos) n_reos++;
      if (inj_eos) n_ieos++;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_starts(input int target);
    for (int k = 0; k < 3000 && n_starts < target; k++) @(negedge clk);
  endtask

  task automatic wait_reos(input int target);
    for (int k = 0; k < 5000 && n_reos < target; k++) @(negedge clk);
    idle(2);
  endtask

  task automatic pulse_trig();
    @(negedge clk); inj_trig = 1'b1;
    @(negedge clk); inj_trig = 1'b0;
  endtask

  task automatic program_lists();
    for (int i = 0; i <= rlen_m1; i++) wr(16 + i, exp_r[i]);
    wr(2, rlen_m1);
    for (int j = 0; j <= ilen_m1; j++) wr(32 + j, exp_i[j]);
    wr(3, ilen_m1);
  endtask

  // expected channel at position p of a run where the priority list (ni slots) breaks in after k normal starts
  function automatic int exp_chan(input int p, input int k, input int ni);
    if (p < k)      return exp_r[p];
    if (p < k + ni) return exp_i[p - k];
    return exp_r[p - ni];
  endfunction

  task automatic cmp_seq(input string req, input int base, input int k, input int ni, input int total);
    int bad = 0, first_act = 0, first_exp = 0;
    for (int p = 0; p < total; p++)
      if (st_chan[base + p] != exp_chan(p, k, ni)) begin
        if (bad == 0) begin first_act = st_chan[base + p]; first_exp = exp_chan(p, k, ni); end
        bad++;
      end
    check(bad == 0, req, "channel order, first mismatching channel", first_act, first_exp);
  endtask

  // normal-list run, started by an enable write; returns start index base
  task automatic run_regular(input string req, output int base);
    int e0, r0;
    base = n_starts; e0 = n_eoc; r0 = n_reos;
    wr(0, 1);
    @(negedge clk);
    check(conv_start == 1'b1, "R3", "start pulse one cycle after enable", conv_start, 1);
    check(conv_chan == 4'(exp_r[0]), "R3", "first channel", conv_chan, exp_r[0]);
    wait_reos(r0 + 1);
    check(n_starts - base == rlen_m1 + 1, req, "conversions in list", n_starts - base, rlen_m1 + 1);
    cmp_seq(req, base, 0, 0, rlen_m1 + 1);
    check(n_eoc - e0 == rlen_m1 + 1, req, "eoc pulses", n_eoc - e0, rlen_m1 + 1);
    check(int'(reg_result) == st_data[n_starts - 1], req, "last result", reg_result, st_data[n_starts - 1]);
  endtask

  initial begin
    #(20 * 190000);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int base, cyc, keep, e0, s0, b0;
    void'($urandom(32'd4711));
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwr_on == 1'b0 && conv_start == 1'b0, "R1", "reset: powered or starting", {pwr_on, conv_start}, 0);
    check(early_flag == 1'b0 && reg_result == '0 && inj_results == '0, "R2", "reset: flag/results", early_flag, 0);

    // lists with repeated channels
    exp_r = '{3, 8, 2, 2, 0, 2, 2, 15, 0, 0, 0, 0, 0, 0, 0, 0};
    exp_i = '{5, 6, 7, 9};
    rlen_m1 = 7; ilen_m1 = 3;
    program_lists();

    // R1 / R2: wake-up with settling count 10 and an early second enable
    wr(1, 10);
    wr(0, 1);
    check(pwr_on == 1'b0, "R1", "powered right after first enable", pwr_on, 0);
    wr(0, 1);
    check(early_flag == 1'b1, "R2", "early flag after enable during wake", early_flag, 1);
    cyc = 2;
    while (!pwr_on && cyc < 100) begin @(negedge clk); cyc++; end
    check(cyc == 11, "R1", "cycles from enable to powered", cyc, 11);
    check(n_starts == 0, "R2", "starts caused by early enable", n_starts, 0);

    // R3 / R4: normal list with repeats
    run_regular("R4", base);
    idle(10);
    check(n_starts == base + 8, "R4", "starts while idle after list end", n_starts - base, 8);

    // R8: stray done while idle
    keep = reg_result; e0 = n_eoc;
    spur_req++;
    idle(4);
    check(int'(reg_result) == keep, "R8", "result after stray done", reg_result, keep);
    check(n_eoc == e0, "R8", "eoc after stray done", n_eoc - e0, 0);

    // R5 / R9: priority list breaks in after the third normal start
    base = n_starts; e0 = n_ieos;
    wr(0, 1);
    wait_starts(base + 3);
    pulse_trig();
    wait_starts(base + 5);
    pulse_trig();
    wait_reos(n_reos + 1);
    check(n_starts - base == 12, "R9", "starts with repeated trigger", n_starts - base, 12);
    cmp_seq("R5", base, 3, 4, 12);
    check(n_ieos - e0 == 1, "R5", "priority end pulses", n_ieos - e0, 1);
    for (int j = 0; j < 4; j++)
      check(int'(inj_results[j*DW +: DW]) == st_data[base + 3 + j], "R5", "priority lane result",
            inj_results[j*DW +: DW], st_data[base + 3 + j]);

    // R7: rewrite slot 0 while its conversion is in flight
    base = n_starts; e0 = n_eoc;
    wr(0, 1);
    wait_starts(base + 1);
    wr(16, 11);
    exp_r[0] = 11;
    wait_reos(n_reos + 1);
    check(st_chan[base] == 3, "R7", "abandoned channel", st_chan[base], 3);
    check(n_starts - base == 9, "R7", "starts incl. restart", n_starts - base, 9);
    cmp_seq("R7", base + 1, 0, 0, 8);
    check(n_eoc - e0 == 8, "R7", "eoc with abandoned done", n_eoc - e0, 8);

    // R6: disable in mid-list
    base = n_starts;
    wr(0, 1);
    wait_starts(base + 2);
    wr(0, 0);
    check(pwr_on == 1'b0, "R6", "powered after disable", pwr_on, 0);
    check(early_flag == 1'b0, "R2", "early flag after disable", early_flag, 0);
    keep = reg_result; e0 = n_eoc; s0 = n_starts;
    idle(20);
    check(n_starts == s0, "R6", "starts after disable", n_starts - s0, 0);
    check(n_eoc == e0 && int'(reg_result) == keep, "R6", "eoc after disable", n_eoc - e0, 0);

    // R9: trigger while powered down
    pulse_trig();
    idle(10);
    check(n_starts == s0, "R9", "starts from trigger while off", n_starts - s0, 0);

    // R1: settling count 0
    wr(1, 0);
    wr(0, 1);
    cyc = 0;
    while (!pwr_on && cyc < 100) begin @(negedge clk); cyc++; end
    check(cyc == 1, "R1", "cycles to powered with count 0", cyc, 1);

    // random lists
    for (int it = 0; it < 4; it++) begin
      rlen_m1 = $urandom_range(15, 0);
      ilen_m1 = $urandom_range(3, 0);
      for (int i = 0; i < 16; i++) exp_r[i] = $urandom_range(15, 0);
      for (int j = 0; j < 4; j++) exp_i[j] = $urandom_range(15, 0);
      program_lists();
      run_regular("R4", base);
      // R5: priority list alone, normal list idle
      b0 = n_starts; e0 = n_ieos;
      pulse_trig();
      for (int k = 0; k < 400 && n_ieos == e0; k++) @(negedge clk);
      idle(2);
      check(n_starts - b0 == ilen_m1 + 1, "R5", "priority-only conversions", n_starts - b0, ilen_m1 + 1);
      cmp_seq("R5", b0, 0, ilen_m1 + 1, ilen_m1 + 1);
      for (int j = 0; j <= ilen_m1; j++)
        check(int'(inj_results[j*DW +: DW]) == st_data[b0 + j], "R5", "priority lane result",
              inj_results[j*DW +: DW], st_data[b0 + j]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule